// File: doc/BRIEF.md
# Mailbox Virtual Register Access Engine

This block is the device side of a small host mailbox that gives byte access to a large internal space of "virtual registers". A host on a byte-wide I/O bus sees nine byte offsets. It loads a 16-bit pointer into a mailbox RAM and assembles a request packet through four data windows that follow the pointer. It then rings a doorbell. A programmable number of clock cycles later, the engine performs a one-byte read or write of its internal register array. It reports the outcome in a status register and in an interrupt source register, and both of these are cleared by host writes.

Reads follow a pairing rule that keeps wide values consistent. A read of the even (low) byte of a 16-bit pair also captures the odd (high) byte into a shadow copy. The next read of the odd address returns that copy, even if the array has changed in between. Bad packets are refused with a distinct status code and never touch the array. The interrupt output follows the completion flag, so firmware can either poll or take the interrupt.

Top module: `vreg_mailbox_engine`

## Requirements
- R1: After a synchronous active-low reset, every offset 0 to 8 reads 0x00, `cmd_irq` is 0, and every mailbox byte and virtual register holds 0x00.
- R2: Offsets 2 and 3 hold the pointer's low and high byte. When the high byte is 0x80 and the low byte is below the mailbox size (16 bytes), window offset 4+k reads and writes mailbox byte (low+k) mod 16. With any other pointer, window writes are ignored and window reads return 0x00.
- R3: Writing 0x01 to offset 0 while idle starts a command. Offset 0 reads 0x01 until completion. Completion (status and interrupt bit 0) becomes visible exactly latency+1 clock edges after the doorbell write edge. Writing any other value to offset 0 has no effect.
- R4: A doorbell write while a command is pending is ignored: completion keeps its original time and happens only once.
- R5: A packet with byte 0 = 0x03 (write) and byte 1 = 0x01 stores mailbox byte 4 into the virtual register at address {byte 7, byte 6}, and the status becomes 0x01.
- R6: A packet with byte 0 = 0x02 (read) and byte 1 = 0x01 places the addressed virtual register value into mailbox byte 4, and the status becomes 0x01.
- R7: Addresses at or above the array depth (64) read as 0x00 and discard writes, and the status is still 0x01.
- R8: An access type other than 0x02/0x03 gives status 0x81. With a valid type, an entry count other than 0x01 gives status 0x82, so the type is checked first. A refused packet still sets interrupt bit 0 and changes neither the array nor mailbox byte 4.
- R9: Writing offset 1 with a value equal to its current content clears it to 0x00. Any other value leaves it unchanged.
- R10: Offset 8 bit 0 is the completion flag. Writing a 1 to that bit clears it, and bits 7:1 always read 0. `cmd_irq` equals bit 0.
- R11: A read command to an even address A captures register A+1 into a shadow copy. The next read command to A+1 returns the captured value once, even if A+1 was written in between. After that, reads of A+1 come from the array again.
- R12: When a completion and a host clear of offset 8 happen on the same clock edge, the completion wins and bit 0 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 4 | Byte offset 0 to 8 for reads and writes |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, sampled on the rising edge |
| io_rdata | output | 8 | Read data for `io_addr` (combinational) |
| resp_latency | input | 8 | Cycles between the doorbell and execution |
| cmd_irq | output | 1 | Completion interrupt, mirrors offset 8 bit 0 |

## Verification
The hardest situation to reach from the ports is a host clear of the interrupt source landing on the very edge where a command completes. The race between the clear and the set only shows on that one edge. The bench counts clock edges from the doorbell write with a fixed latency and times its clear write so that the strobe is sampled on the completion edge. The shadow rule is another hard case: the bench writes the odd register between the paired reads, so that the returned value can only come from the captured copy.

// File: rtl/vmb_pkg.sv
// Package: shared constants and types of the mailbox virtual register engine.
// Assumes byte-wide host accesses and a one-entry packet layout at region start.
package vmb_pkg;
    // host byte offsets
    localparam logic [3:0] OFF_DOORBELL = 4'd0;
    localparam logic [3:0] OFF_STATUS   = 4'd1;
    localparam logic [3:0] OFF_PTR_LO   = 4'd2;
    localparam logic [3:0] OFF_PTR_HI   = 4'd3;
    localparam logic [3:0] OFF_INTSRC   = 4'd8;

    // codes
    localparam logic [7:0] ACC_READ     = 8'h02;
    localparam logic [7:0] ACC_WRITE    = 8'h03;
    localparam logic [7:0] ONE_ENTRY    = 8'h01;
    localparam logic [7:0] RING_CODE    = 8'h01;
    localparam logic [7:0] ST_OK        = 8'h01;
    localparam logic [7:0] ST_BAD_TYPE  = 8'h81;
    localparam logic [7:0] ST_BAD_COUNT = 8'h82;
    localparam logic [7:0] REGION_HI    = 8'h80;

    // packet byte positions relative to region start
    localparam int PK_TYPE = 0;
    localparam int PK_CNT  = 1;
    localparam int PK_VAL  = 4;
    localparam int PK_ALO  = 6;
    localparam int PK_AHI  = 7;

    typedef struct packed {
        logic [7:0]  acc;
        logic [7:0]  cnt;
        logic [7:0]  val;
        logic [15:0] vaddr;
    } vmb_pkt_t;

    typedef enum logic {ENG_IDLE, ENG_WAIT} eng_state_t;
endpackage

// File: rtl/vmb_mailbox_ram.sv
// Mailbox RAM: byte storage seen by the host through windows and by the engine
// through fixed packet fields. Assumes MB_BYTES is a power of two and at least 8.
// On an index collision the engine write wins over the host write.
module vmb_mailbox_ram
    import vmb_pkg::*;
#(
    parameter int MB_BYTES = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_we,
    input  logic [$clog2(MB_BYTES)-1:0] host_idx,
    input  logic [7:0]                  host_wdata,
    output logic [7:0]                  host_rdata,
    input  logic                        eng_we,
    input  logic [$clog2(MB_BYTES)-1:0] eng_idx,
    input  logic [7:0]                  eng_wdata,
    output vmb_pkt_t                    pkt
);
    localparam int MB_IW = $clog2(MB_BYTES);

    logic [7:0] mem [MB_BYTES];

    // byte storage update, engine after host so it takes priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MB_BYTES; i++) mem[i] <= 8'h00;
        end else begin
            if (host_we) mem[host_idx] <= host_wdata;
            if (eng_we)  mem[eng_idx]  <= eng_wdata;
        end
    end

    // host window read and packet field extraction
    always_comb begin
        host_rdata = mem[host_idx];
        pkt.acc    = mem[MB_IW'(PK_TYPE)];
        pkt.cnt    = mem[MB_IW'(PK_CNT)];
        pkt.val    = mem[MB_IW'(PK_VAL)];
        pkt.vaddr  = {mem[MB_IW'(PK_AHI)], mem[MB_IW'(PK_ALO)]};
    end

    // R6
    eng_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |=> mem[$past(eng_idx)] == $past(eng_wdata));
endmodule

// File: rtl/vmb_vreg_array.sv
// Virtual register array with a pair shadow. A read of an even address captures
// the odd partner, and the next read of that partner returns the capture once.
// Assumes DEPTH is a power of two, at most 65536. Out-of-range accesses read 0
// and drop writes.
module vmb_vreg_array #(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]    mem [DEPTH];
    logic [7:0]    sh_val;
    logic [15:0]   sh_tag;
    logic          sh_vld;
    logic          in_range, nxt_in_range, shadow_hit;
    logic [15:0]   nxt_addr;
    logic [IW-1:0] idx, nxt_idx;

    // address decode and shadow match
    always_comb begin
        nxt_addr     = addr | 16'h0001;
        in_range     = ({16'd0, addr} < DEPTH);
        nxt_in_range = ({16'd0, nxt_addr} < DEPTH);
        idx          = addr[IW-1:0];
        nxt_idx      = nxt_addr[IW-1:0];
        shadow_hit   = addr[0] && sh_vld && (sh_tag == addr);
    end

    // read data: shadow copy first, then array, else zero
    always_comb begin
        if (shadow_hit)    rdata = sh_val;
        else if (in_range) rdata = mem[idx];
        else               rdata = 8'h00;
    end

    // array write and shadow capture/consume
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
            sh_val <= 8'h00;
            sh_tag <= 16'h0000;
            sh_vld <= 1'b0;
        end else begin
            if (wr_en && in_range) mem[idx] <= wdata;
            if (rd_en) begin
                if (shadow_hit) begin
                    sh_vld <= 1'b0;
                end else if (!addr[0]) begin
                    sh_vld <= 1'b1;
                    sh_tag <= nxt_addr;
                    sh_val <= nxt_in_range ? mem[nxt_idx] : 8'h00;
                end
            end
        end
    end

    // R11
    shadow_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && shadow_hit |=> !sh_vld);
    // R5
    array_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && in_range |=> mem[$past(idx)] == $past(wdata));
endmodule

// File: rtl/vmb_cmd_engine.sv
// Command engine: a doorbell starts a latency count, then the packet is decoded
// and executed in one cycle. It owns the status and interrupt source registers.
// Assumes pkt is stable while a command is pending. Completion wins over host
// clears on the same edge.
module vmb_cmd_engine
    import vmb_pkg::*;
#(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ring,
    input  logic [LAT_W-1:0] latency,
    input  vmb_pkt_t         pkt,
    input  logic             st_wr,
    input  logic             int_wr,
    input  logic [7:0]       host_wdata,
    output logic             busy,
    output logic [7:0]       status,
    output logic             int_flag,
    output logic             va_rd_en,
    output logic             va_wr_en,
    output logic [15:0]      va_addr,
    output logic [7:0]       va_wdata,
    input  logic [7:0]       va_rdata,
    output logic             mb_we,
    output logic [7:0]       mb_wdata
);
    eng_state_t       state;
    logic [LAT_W-1:0] cnt;
    logic             exec, type_ok, cnt_ok, is_read;
    logic [7:0]       code;

    // packet decode and execution strobes
    always_comb begin
        exec     = (state == ENG_WAIT) && (cnt == '0);
        is_read  = (pkt.acc == ACC_READ);
        type_ok  = is_read || (pkt.acc == ACC_WRITE);
        cnt_ok   = (pkt.cnt == ONE_ENTRY);
        if (!type_ok)     code = ST_BAD_TYPE;
        else if (!cnt_ok) code = ST_BAD_COUNT;
        else              code = ST_OK;
        va_rd_en = exec && type_ok && cnt_ok && is_read;
        va_wr_en = exec && type_ok && cnt_ok && !is_read;
        va_addr  = pkt.vaddr;
        va_wdata = pkt.val;
        mb_we    = va_rd_en;
        mb_wdata = va_rdata;
        busy     = (state == ENG_WAIT);
    end

    // latency counter and pending state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ENG_IDLE;
            cnt   <= '0;
        end else if (state == ENG_IDLE) begin
            if (ring) begin
                state <= ENG_WAIT;
                cnt   <= latency;
            end
        end else if (cnt == '0) begin
            state <= ENG_IDLE;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // status register, cleared by writing back its own value
    always_ff @(posedge clk) begin
        if (!rst_n)                             status <= 8'h00;
        else if (exec)                          status <= code;
        else if (st_wr && host_wdata == status) status <= 8'h00;
    end

    // interrupt source bit 0, write one to clear
    always_ff @(posedge clk) begin
        if (!rst_n)                         int_flag <= 1'b0;
        else if (exec)                      int_flag <= 1'b1;
        else if (int_wr && host_wdata[0])   int_flag <= 1'b0;
    end

    // R4
    latency_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ENG_WAIT && cnt != '0 |=> state == ENG_WAIT && cnt == $past(cnt) - 1'b1);
    // R10
    int_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> int_flag);
    // R9
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr && !exec && status != 8'h00 && host_wdata == status |=> status == 8'h00);
    // R8
    bad_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec && pkt.acc != ACC_READ && pkt.acc != ACC_WRITE |=> status == ST_BAD_TYPE);
endmodule

// File: rtl/vreg_mailbox_engine.sv
// Top: host byte-bus decode for the nine mailbox offsets, pointer registers,
// window mapping and readback mux around the RAM, engine and register array.
// Assumes one host access per cycle; reads have no side effects.
module vreg_mailbox_engine
    import vmb_pkg::*;
#(
    parameter int MB_BYTES   = 16,
    parameter int VREG_DEPTH = 64,
    parameter int LAT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       io_addr,
    input  logic [7:0]       io_wdata,
    input  logic             io_wr,
    output logic [7:0]       io_rdata,
    input  logic [LAT_W-1:0] resp_latency,
    output logic             cmd_irq
);
    localparam int MB_IW = $clog2(MB_BYTES);

    logic [7:0]       ptr_lo, ptr_hi;
    logic             win_sel, in_region, ring, host_we;
    logic [MB_IW-1:0] win_idx;
    logic [7:0]       mb_rdata;
    vmb_pkt_t         pkt;
    logic             busy, int_flag, va_rd_en, va_wr_en, mb_we;
    logic [7:0]       status, va_wdata, va_rdata, mb_wdata;
    logic [15:0]      va_addr;

    // host decode and window index
    always_comb begin
        win_sel   = (io_addr[3:2] == 2'b01);
        in_region = (ptr_hi == REGION_HI) && ((ptr_lo >> MB_IW) == 8'h00);
        win_idx   = ptr_lo[MB_IW-1:0] + MB_IW'(io_addr[1:0]);
        ring      = io_wr && (io_addr == OFF_DOORBELL) && (io_wdata == RING_CODE);
        host_we   = io_wr && win_sel && in_region;
    end

    // pointer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_lo <= 8'h00;
            ptr_hi <= 8'h00;
        end else if (io_wr) begin
            if (io_addr == OFF_PTR_LO) ptr_lo <= io_wdata;
            if (io_addr == OFF_PTR_HI) ptr_hi <= io_wdata;
        end
    end

    vmb_mailbox_ram #(.MB_BYTES(MB_BYTES)) ram_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_idx   (win_idx),
        .host_wdata (io_wdata),
        .host_rdata (mb_rdata),
        .eng_we     (mb_we),
        .eng_idx    (MB_IW'(PK_VAL)),
        .eng_wdata  (mb_wdata),
        .pkt        (pkt)
    );

    vmb_cmd_engine #(.LAT_W(LAT_W)) eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring       (ring),
        .latency    (resp_latency),
        .pkt        (pkt),
        .st_wr      (io_wr && io_addr == OFF_STATUS),
        .int_wr     (io_wr && io_addr == OFF_INTSRC),
        .host_wdata (io_wdata),
        .busy       (busy),
        .status     (status),
        .int_flag   (int_flag),
        .va_rd_en   (va_rd_en),
        .va_wr_en   (va_wr_en),
        .va_addr    (va_addr),
        .va_wdata   (va_wdata),
        .va_rdata   (va_rdata),
        .mb_we      (mb_we),
        .mb_wdata   (mb_wdata)
    );

    vmb_vreg_array #(.DEPTH(VREG_DEPTH)) arr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (va_rd_en),
        .wr_en (va_wr_en),
        .addr  (va_addr),
        .wdata (va_wdata),
        .rdata (va_rdata)
    );

    // readback mux
    always_comb begin
        io_rdata = 8'h00;
        if (win_sel) begin
            io_rdata = in_region ? mb_rdata : 8'h00;
        end else begin
            case (io_addr)
                OFF_DOORBELL: io_rdata = {7'd0, busy};
                OFF_STATUS:   io_rdata = status;
                OFF_PTR_LO:   io_rdata = ptr_lo;
                OFF_PTR_HI:   io_rdata = ptr_hi;
                OFF_INTSRC:   io_rdata = {7'd0, int_flag};
                default:      io_rdata = 8'h00;
            endcase
        end
        cmd_irq = int_flag;
    end

    // R2
    window_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_sel && !in_region |-> io_rdata == 8'h00);
endmodule

// File: tb/vreg_mailbox_engine_tb.sv
module vreg_mailbox_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] io_addr = 4'd0;
    logic [7:0] io_wdata = 8'h00;
    logic       io_wr = 1'b0;
    logic [7:0] io_rdata;
    logic [7:0] resp_latency = 8'(LAT);
    logic       cmd_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vreg_mailbox_engine dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rdata(io_rdata), .resp_latency(resp_latency),
        .cmd_irq(cmd_irq)
    );

    // vector: {is_write, vaddr[15:0], data[7:0], expected byte4[7:0]}
    localparam logic [32:0] VEC [9] = '{
        {1'b1, 16'h0010, 8'hA5, 8'hA5},
        {1'b0, 16'h0010, 8'h00, 8'hA5},
        {1'b1, 16'h003F, 8'h77, 8'h77},
        {1'b0, 16'h003F, 8'h00, 8'h77},
        {1'b1, 16'h0100, 8'h5A, 8'h5A},
        {1'b0, 16'h0100, 8'h00, 8'h00},
        {1'b0, 16'h0005, 8'h00, 8'h00},
        {1'b1, 16'h0000, 8'hC3, 8'hC3},
        {1'b0, 16'h0000, 8'h00, 8'hC3}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        io_addr = a;
        #1;
        d = io_rdata;
    endtask

    task automatic build_pkt(input logic [7:0] typ, input logic [7:0] cnt,
                             input logic [15:0] va, input logic [7:0] val);
        bus_write(4'd2, 8'h00);
        bus_write(4'd3, 8'h80);
        bus_write(4'd4, typ);
        bus_write(4'd5, cnt);
        bus_write(4'd2, 8'h04);
        bus_write(4'd4, val);
        bus_write(4'd6, va[7:0]);
        bus_write(4'd7, va[15:8]);
    endtask

    task automatic wait_done();
        logic [7:0] r;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            peek(4'd8, r);
            if (r[0]) break;
        end
    endtask

    task automatic clear_flags();
        logic [7:0] s;
        peek(4'd1, s);
        bus_write(4'd1, s);
        bus_write(4'd8, 8'h01);
    endtask

    task automatic run_cmd(input logic [7:0] typ, input logic [7:0] cnt,
                           input logic [15:0] va, input logic [7:0] val,
                           output logic [7:0] st, output logic [7:0] res);
        build_pkt(typ, cnt, va, val);
        bus_write(4'd0, 8'h01);
        wait_done();
        peek(4'd1, st);
        peek(4'd4, res);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual 0x00 expected 0x01");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, st, res;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state of every offset
        for (int a = 0; a <= 8; a++) begin
            peek(4'(a), r);
            check("R1 offset read", r, 8'h00);
        end
        check("R1 irq", {7'd0, cmd_irq}, 8'h00);

        // R2 windows follow the pointer and wrap
        bus_write(4'd3, 8'h80);
        bus_write(4'd2, 8'h00);
        bus_write(4'd4, 8'h11);
        bus_write(4'd5, 8'h22);
        bus_write(4'd6, 8'h33);
        bus_write(4'd7, 8'h44);
        bus_write(4'd2, 8'h02);
        peek(4'd4, r); check("R2 window ptr+0", r, 8'h33);
        peek(4'd5, r); check("R2 window ptr+1", r, 8'h44);
        bus_write(4'd2, 8'h0E);
        peek(4'd6, r); check("R2 window wrap", r, 8'h11);
        bus_write(4'd3, 8'h00);
        bus_write(4'd2, 8'h00);
        bus_write(4'd4, 8'hEE);
        peek(4'd4, r); check("R2 outside region reads 0", r, 8'h00);
        bus_write(4'd3, 8'h80);
        peek(4'd4, r); check("R2 outside write ignored", r, 8'h11);

        // table: R5 R6 R7 vectors
        resp_latency = 8'd3;
        for (int i = 0; i < 9; i++) begin
            run_cmd(VEC[i][32] ? 8'h03 : 8'h02, 8'h01, VEC[i][31:16], VEC[i][15:8], st, res);
            check("R5/R6/R7 vector status", st, 8'h01);
            check("R5/R6/R7 vector value", res, VEC[i][7:0]);
            clear_flags();
        end
        resp_latency = 8'(LAT);

        // R3 exact completion time and busy flag
        build_pkt(8'h02, 8'h01, 16'h0010, 8'h00);
        bus_write(4'd0, 8'h01);
        peek(4'd0, r); check("R3 busy", r, 8'h01);
        repeat (LAT) @(negedge clk);
        peek(4'd8, r); check("R3 not early", r, 8'h00);
        @(negedge clk);
        peek(4'd8, r); check("R3 on time", r, 8'h01);
        peek(4'd0, r); check("R3 idle after", r, 8'h00);
        clear_flags();
        // R3 wrong doorbell value
        bus_write(4'd0, 8'h02);
        repeat (LAT + 4) @(negedge clk);
        peek(4'd8, r); check("R3 wrong doorbell value", r, 8'h00);

        // R4 second doorbell while pending
        bus_write(4'd0, 8'h01);
        bus_write(4'd0, 8'h01);
        repeat (LAT - 2) @(negedge clk);
        peek(4'd8, r); check("R4 not restarted early", r, 8'h00);
        @(negedge clk);
        peek(4'd8, r); check("R4 original time", r, 8'h01);
        clear_flags();
        repeat (LAT + 6) @(negedge clk);
        peek(4'd8, r); check("R4 single completion", r, 8'h00);

        // R8 refused packets
        run_cmd(8'h05, 8'h01, 16'h0010, 8'h00, st, res);
        check("R8 bad type status", st, 8'h81);
        peek(4'd8, r); check("R8 irq on bad type", r, 8'h01);
        clear_flags();
        run_cmd(8'h02, 8'h02, 16'h0010, 8'h66, st, res);
        check("R8 bad count status", st, 8'h82);
        check("R8 byte4 untouched", res, 8'h66);
        clear_flags();
        run_cmd(8'h07, 8'h03, 16'h0010, 8'h00, st, res);
        check("R8 type checked first", st, 8'h81);
        clear_flags();
        run_cmd(8'h03, 8'h02, 16'h0010, 8'hFF, st, res);
        clear_flags();
        run_cmd(8'h02, 8'h01, 16'h0010, 8'h00, st, res);
        check("R8 array unchanged", res, 8'hA5);

        // R9 status write-back clear
        bus_write(4'd1, 8'h02);
        peek(4'd1, r); check("R9 wrong value keeps", r, 8'h01);
        bus_write(4'd1, 8'h01);
        peek(4'd1, r); check("R9 matching value clears", r, 8'h00);

        // R10 interrupt source clear
        bus_write(4'd8, 8'h00);
        peek(4'd8, r); check("R10 zero write keeps", r, 8'h01);
        bus_write(4'd8, 8'hFE);
        peek(4'd8, r); check("R10 upper bits keep", r, 8'h01);
        check("R10 irq high", {7'd0, cmd_irq}, 8'h01);
        bus_write(4'd8, 8'h01);
        peek(4'd8, r); check("R10 clear", r, 8'h00);
        check("R10 irq low", {7'd0, cmd_irq}, 8'h00);

        // R11 pair shadow
        run_cmd(8'h03, 8'h01, 16'h0020, 8'h11, st, res); clear_flags();
        run_cmd(8'h03, 8'h01, 16'h0021, 8'h22, st, res); clear_flags();
        run_cmd(8'h02, 8'h01, 16'h0020, 8'h00, st, res); clear_flags();
        check("R11 low byte", res, 8'h11);
        run_cmd(8'h03, 8'h01, 16'h0021, 8'h99, st, res); clear_flags();
        run_cmd(8'h02, 8'h01, 16'h0021, 8'h00, st, res); clear_flags();
        check("R11 shadow copy", res, 8'h22);
        run_cmd(8'h02, 8'h01, 16'h0021, 8'h00, st, res); clear_flags();
        check("R11 shadow used once", res, 8'h99);

        // R12 clear on the completion edge
        build_pkt(8'h02, 8'h01, 16'h0010, 8'h00);
        bus_write(4'd0, 8'h01);
        repeat (LAT - 1) @(negedge clk);
        bus_write(4'd8, 8'h01);
        peek(4'd8, r); check("R12 completion wins", r, 8'h01);
        peek(4'd1, r); check("R12 status ok", r, 8'h01);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule